// File: doc/BRIEF.md
# Register-Programmed Burst Traffic Generator

This block loads a memory-mapped link with a stream of same-sized read or write bursts aimed at one 64-bit target address, so that software can measure throughput. Software programs it through a simple 32-bit register port: a target base address, a burst count with a continuous-run flag, a control word that carries a start doorbell, a payload seed and a status word. On the master side the block hands out one request descriptor per burst over a valid/ready handshake. Each descriptor carries the address, the length in 32-bit words, the direction, the first payload word and a flag that says whether payload words step upward.

Two 64-bit tallies count the bytes of accepted write descriptors and of accepted read descriptors. They advance only while a counter-enable bit is set. With the bit clear they hold their value, so software can read the upper and lower halves as a consistent pair. To get a rate, software takes two snapshots a known time apart and divides the difference by that time.

The descriptor port follows these back-pressure rules. Once `dsc_valid` is high, it stays high and every descriptor field stays unchanged until a cycle in which `dsc_ready` is high. A descriptor is transferred on each rising clock edge where both signals are high. The next descriptor, if there is one, is presented in the cycle that follows. The engine never waits on anything other than `dsc_ready`.

Top module: `blg_top`

## Requirements
- R1: Register words are decoded from the byte address with bits 1:0 ignored. The layout is: 0x000 base bits 31:0, 0x004 base bits 63:32, 0x008 burst word, 0x00C control, 0x010 pattern, 0x014 status, 0x018 and 0x01C two plain storage words, 0x058 counter enable. The write tally sits at 0x100 (low) and 0x104 (high), the read tally at 0x108 (low) and 0x10C (high). The base, burst, pattern and storage words read back exactly as written. The counter-enable word reads back only bit 5. Control reads back only bits 0, 1, 13:2, 16 and 18. Every other offset reads zero.
- R2: Writing control with bit 0 set rings the doorbell. Bit 0 reads 1 in the cycle after the write and 0 afterwards. A doorbell that arrives while a run is active is dropped: it is not queued and it does not change the run in progress.
- R3: A doorbell rung while idle with burst bit 31 clear issues exactly N descriptors, where N is burst bits 30:0. The engine then sets done (status bit 0) and returns to idle. If N is zero, done is set in the cycle after the doorbell and no descriptor appears. Status bit 1 reads 1 while a run is active.
- R4: If burst bit 31 is set when the doorbell rings, descriptors keep coming until software clears bit 31. The descriptor accepted first after the clear is the last one, and done is then set. A read-modify-write that clears bit 31 leaves bits 30:0 as they were.
- R5: Descriptor k of a run (counting from 0) carries address base + 4·k·L, modulo 2^64, where L is control bits 13:2. If control bit 18 was set at the doorbell, every descriptor carries the base address.
- R6: If control bit 16 was set at the doorbell, descriptor k carries seed pattern + k·L (modulo 2^32) with the increment flag high, so the payload continues word by word across bursts. Otherwise every seed equals the pattern and the flag is low.
- R7: Every descriptor carries the length L and a direction equal to control bit 1 (1 = write, 0 = read), both captured at the doorbell.
- R8: While `dsc_valid` is high and `dsc_ready` is low, valid stays high and every descriptor field stays unchanged on the next cycle.
- R9: A status write with bit 0 at 0 clears done. A status write with bit 0 at 1 leaves it unchanged.
- R10: While counter-enable bit 5 is 1, each accepted descriptor adds 4·L to the write tally if it is a write, or to the read tally if it is a read. While bit 5 is 0 both tallies hold their value.
- R11: After reset every register and both tallies read zero, and `dsc_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 9 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr`, combinational |
| dsc_valid | output | 1 | Descriptor valid |
| dsc_ready | input | 1 | Descriptor accepted by the downstream consumer |
| dsc_addr | output | 64 | Burst target byte address |
| dsc_words | output | 12 | Burst length in 32-bit words |
| dsc_write | output | 1 | 1 = write burst, 0 = read burst |
| dsc_incr | output | 1 | Payload words step by one |
| dsc_seed | output | 32 | First payload word of this burst |

## Verification
Each piece of engine state shows up at the ports within one descriptor. A wrong issued count or a wrong stop decision shows as one descriptor too many or too few, or as done rising too early or too late, in the cycle after the final handshake. A corrupted address or seed accumulator gives a wrong address or seed on the very next descriptor. The tallies are checked after every group of runs against a byte total the bench keeps itself. A slip in enable gating or in direction selection therefore shows on the next read of the tallies, and a stall that lets descriptor fields drift shows one cycle after the stall begins.

// File: rtl/blg_pkg.sv
package blg_pkg;
  localparam int REG_AW = 9;
  localparam int LEN_W  = 12;
  localparam int BYTE_W = LEN_W + 2;
  localparam int BCNT_W = 31;
  localparam int DATA_W = 32;
  localparam int BASE_W = 64;

  localparam logic [REG_AW-1:0] OFS_BASE_LO = 9'h000;
  localparam logic [REG_AW-1:0] OFS_BASE_HI = 9'h004;
  localparam logic [REG_AW-1:0] OFS_BURST   = 9'h008;
  localparam logic [REG_AW-1:0] OFS_CTRL    = 9'h00C;
  localparam logic [REG_AW-1:0] OFS_PAT     = 9'h010;
  localparam logic [REG_AW-1:0] OFS_STAT    = 9'h014;
  localparam logic [REG_AW-1:0] OFS_SCR0    = 9'h018;
  localparam logic [REG_AW-1:0] OFS_SCR1    = 9'h01C;
  localparam logic [REG_AW-1:0] OFS_CTREN   = 9'h058;
  localparam logic [REG_AW-1:0] OFS_WR_LO   = 9'h100;
  localparam logic [REG_AW-1:0] OFS_WR_HI   = 9'h104;
  localparam logic [REG_AW-1:0] OFS_RD_LO   = 9'h108;
  localparam logic [REG_AW-1:0] OFS_RD_HI   = 9'h10C;

  localparam int CB_BELL  = 0;
  localparam int CB_DIR   = 1;
  localparam int CB_LEN   = 2;
  localparam int CB_INC   = 16;
  localparam int CB_FIX   = 18;
  localparam int BB_REP   = 31;
  localparam int EB_COUNT = 5;

  typedef enum logic {ENG_IDLE, ENG_RUN} eng_state_e;
endpackage

// File: rtl/blg_regs.sv
module blg_regs
  import blg_pkg::*;
#(
  parameter int CTR_W = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [REG_AW-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  output logic [BASE_W-1:0]   base,
  output logic [DATA_W-1:0]   burst,
  output logic                bell,
  output logic                c_dir,
  output logic [LEN_W-1:0]    c_len,
  output logic                c_inc,
  output logic                c_fix,
  output logic [DATA_W-1:0]   pattern,
  output logic                ctr_en,
  input  logic                done_evt,
  input  logic                busy,
  input  logic [CTR_W-1:0]    wr_cnt,
  input  logic [CTR_W-1:0]    rd_cnt
);
  logic [REG_AW-1:0] wa;
  logic [DATA_W-1:0] scr0_q, scr1_q;
  logic              done_q;
  logic [63:0]       wr64, rd64;

  assign wa   = {addr[REG_AW-1:2], 2'b00};
  assign wr64 = 64'(wr_cnt);
  assign rd64 = 64'(rd_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base    <= '0;
      burst   <= '0;
      bell    <= 1'b0;
      c_dir   <= 1'b0;
      c_len   <= '0;
      c_inc   <= 1'b0;
      c_fix   <= 1'b0;
      pattern <= '0;
      scr0_q  <= '0;
      scr1_q  <= '0;
      ctr_en  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      bell <= 1'b0;
      if (done_evt)
        done_q <= 1'b1;
      else if (we && wa == OFS_STAT && !wdata[0])
        done_q <= 1'b0;
      if (we) begin
        case (wa)
          OFS_BASE_LO: base[31:0]  <= wdata;
          OFS_BASE_HI: base[63:32] <= wdata;
          OFS_BURST:   burst       <= wdata;
          OFS_PAT:     pattern     <= wdata;
          OFS_SCR0:    scr0_q      <= wdata;
          OFS_SCR1:    scr1_q      <= wdata;
          OFS_CTREN:   ctr_en      <= wdata[EB_COUNT];
          OFS_CTRL: begin
            bell  <= wdata[CB_BELL];
            c_dir <= wdata[CB_DIR];
            c_len <= wdata[CB_LEN +: LEN_W];
            c_inc <= wdata[CB_INC];
            c_fix <= wdata[CB_FIX];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (wa)
      OFS_BASE_LO: rdata = base[31:0];
      OFS_BASE_HI: rdata = base[63:32];
      OFS_BURST:   rdata = burst;
      OFS_CTRL:    rdata = {13'b0, c_fix, 1'b0, c_inc, 2'b0, c_len, c_dir, bell};
      OFS_PAT:     rdata = pattern;
      OFS_STAT:    rdata = {30'b0, busy, done_q};
      OFS_SCR0:    rdata = scr0_q;
      OFS_SCR1:    rdata = scr1_q;
      OFS_CTREN:   rdata = {26'b0, ctr_en, 5'b0};
      OFS_WR_LO:   rdata = wr64[31:0];
      OFS_WR_HI:   rdata = wr64[63:32];
      OFS_RD_LO:   rdata = rd64[31:0];
      OFS_RD_HI:   rdata = rd64[63:32];
      default:     rdata = '0;
    endcase
  end

  // R3: done may only appear once the engine has gone idle
  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> !busy);
endmodule

// File: rtl/blg_engine.sv
module blg_engine
  import blg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bell,
  input  logic [DATA_W-1:0]   burst,
  input  logic [BASE_W-1:0]   base,
  input  logic                c_dir,
  input  logic [LEN_W-1:0]    c_len,
  input  logic                c_inc,
  input  logic                c_fix,
  input  logic [DATA_W-1:0]   pattern,
  input  logic                dsc_ready,
  output logic                dsc_valid,
  output logic [BASE_W-1:0]   dsc_addr,
  output logic [LEN_W-1:0]    dsc_words,
  output logic                dsc_write,
  output logic                dsc_incr,
  output logic [DATA_W-1:0]   dsc_seed,
  output logic                busy,
  output logic                fire,
  output logic                done_evt
);
  eng_state_e         st_q;
  logic [BCNT_W-1:0]  goal_q, sent_q;
  logic [BCNT_W:0]    sent_nx;
  logic [BASE_W-1:0]  addr_q, step;
  logic [DATA_W-1:0]  seed_q;
  logic [LEN_W-1:0]   len_q;
  logic               dir_q, inc_q, fix_q, rep_q;
  logic               last, empty_start;

  assign busy        = (st_q == ENG_RUN);
  assign dsc_valid   = busy;
  assign fire        = busy && dsc_ready;
  assign sent_nx     = {1'b0, sent_q} + 1'b1;
  assign step        = BASE_W'({len_q, 2'b00});
  assign last        = rep_q ? !burst[BB_REP] : (sent_nx >= {1'b0, goal_q});
  assign empty_start = (st_q == ENG_IDLE) && bell && !burst[BB_REP]
                       && (burst[BCNT_W-1:0] == '0);
  assign done_evt    = empty_start || (fire && last);

  assign dsc_addr  = addr_q;
  assign dsc_words = len_q;
  assign dsc_write = dir_q;
  assign dsc_incr  = inc_q;
  assign dsc_seed  = seed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ENG_IDLE;
      goal_q <= '0;
      sent_q <= '0;
      addr_q <= '0;
      seed_q <= '0;
      len_q  <= '0;
      dir_q  <= 1'b0;
      inc_q  <= 1'b0;
      fix_q  <= 1'b0;
      rep_q  <= 1'b0;
    end else begin
      case (st_q)
        ENG_IDLE: begin
          if (bell) begin
            addr_q <= base;
            seed_q <= pattern;
            len_q  <= c_len;
            dir_q  <= c_dir;
            inc_q  <= c_inc;
            fix_q  <= c_fix;
            rep_q  <= burst[BB_REP];
            goal_q <= burst[BCNT_W-1:0];
            sent_q <= '0;
            if (!empty_start) st_q <= ENG_RUN;
          end
        end
        ENG_RUN: begin
          if (fire) begin
            sent_q <= sent_nx[BCNT_W-1:0];
            if (!fix_q) addr_q <= addr_q + step;
            if (inc_q)  seed_q <= seed_q + DATA_W'(len_q);
            if (last)   st_q   <= ENG_IDLE;
          end
        end
        default: st_q <= ENG_IDLE;
      endcase
    end
  end

  // R8: stalled descriptor stays put
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_valid && !dsc_ready |=> dsc_valid && $stable(dsc_addr) && $stable(dsc_seed)
                               && $stable(dsc_words) && $stable(dsc_write) && $stable(dsc_incr));
  // R5: frozen address never moves across a handshake
  p_fixed_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire && fix_q |=> $stable(dsc_addr));
  // R3: a counted run never overshoots its quota
  p_quota_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !rep_q |-> sent_q < goal_q);
  // R2: traffic begins only right after a doorbell
  p_start_bell_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dsc_valid) |-> $past(bell));
endmodule

// File: rtl/blg_tally.sv
module blg_tally
  import blg_pkg::*;
#(
  parameter int CTR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              fire,
  input  logic              is_wr,
  input  logic [BYTE_W-1:0] bytes,
  output logic [CTR_W-1:0]  wr_cnt,
  output logic [CTR_W-1:0]  rd_cnt
);
  localparam int NDIR = 2;
  logic [CTR_W-1:0] cnt [NDIR];

  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    logic hit;
    assign hit = en && fire && (is_wr == (g == 0));
    always_ff @(posedge clk) begin
      if (!rst_n)   cnt[g] <= '0;
      else if (hit) cnt[g] <= cnt[g] + CTR_W'(bytes);
    end
    // R10: tallies frozen while counting is disabled
    p_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(cnt[g]));
  end

  assign wr_cnt = cnt[0];
  assign rd_cnt = cnt[1];
endmodule

// File: rtl/blg_top.sv
module blg_top
  import blg_pkg::*;
#(
  parameter int CTR_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [REG_AW-1:0]  cfg_addr,
  input  logic [DATA_W-1:0]  cfg_wdata,
  output logic [DATA_W-1:0]  cfg_rdata,
  output logic               dsc_valid,
  input  logic               dsc_ready,
  output logic [BASE_W-1:0]  dsc_addr,
  output logic [LEN_W-1:0]   dsc_words,
  output logic               dsc_write,
  output logic               dsc_incr,
  output logic [DATA_W-1:0]  dsc_seed
);
  logic [BASE_W-1:0] base;
  logic [DATA_W-1:0] burst, pattern;
  logic              bell, c_dir, c_inc, c_fix, ctr_en;
  logic [LEN_W-1:0]  c_len;
  logic              busy, fire, done_evt;
  logic [CTR_W-1:0]  wr_cnt, rd_cnt;

  blg_regs #(.CTR_W(CTR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .base(base), .burst(burst), .bell(bell), .c_dir(c_dir),
    .c_len(c_len), .c_inc(c_inc), .c_fix(c_fix), .pattern(pattern), .ctr_en(ctr_en),
    .done_evt(done_evt), .busy(busy), .wr_cnt(wr_cnt), .rd_cnt(rd_cnt)
  );

  blg_engine u_engine (
    .clk(clk), .rst_n(rst_n), .bell(bell), .burst(burst), .base(base),
    .c_dir(c_dir), .c_len(c_len), .c_inc(c_inc), .c_fix(c_fix), .pattern(pattern),
    .dsc_ready(dsc_ready), .dsc_valid(dsc_valid), .dsc_addr(dsc_addr),
    .dsc_words(dsc_words), .dsc_write(dsc_write), .dsc_incr(dsc_incr),
    .dsc_seed(dsc_seed), .busy(busy), .fire(fire), .done_evt(done_evt)
  );

  blg_tally #(.CTR_W(CTR_W)) u_tally (
    .clk(clk), .rst_n(rst_n), .en(ctr_en), .fire(fire), .is_wr(dsc_write),
    .bytes({dsc_words, 2'b00}), .wr_cnt(wr_cnt), .rd_cnt(rd_cnt)
  );
endmodule

// File: tb/blg_top_test.sv
module blg_top_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [8:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        dsc_valid;
  logic        dsc_ready = 1'b0;
  logic [63:0] dsc_addr;
  logic [11:0] dsc_words;
  logic        dsc_write, dsc_incr;
  logic [31:0] dsc_seed;

  int nchk = 0;
  int nfail = 0;
  bit ended = 0;

  logic [63:0] j_base;
  logic [31:0] j_pat;
  int          j_len, j_k;
  bit          j_wr, j_inc, j_fix, ctr_on;
  logic [63:0] exp_wr = '0, exp_rd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blg_top uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dsc_valid(dsc_valid),
    .dsc_ready(dsc_ready), .dsc_addr(dsc_addr), .dsc_words(dsc_words),
    .dsc_write(dsc_write), .dsc_incr(dsc_incr), .dsc_seed(dsc_seed)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  endtask

  task automatic reg_wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [8:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  function automatic logic [31:0] ctrl_word(input bit bell, input bit wr, input int len,
                                            input bit inc, input bit fix);
    return 32'(bell) | (32'(wr) << 1) | ((32'(len) & 32'hFFF) << 2)
         | (32'(inc) << 16) | (32'(fix) << 18);
  endfunction

  function automatic logic [63:0] e_addr(input int k);
    return j_fix ? j_base : j_base + 64'(k) * 64'(j_len) * 64'd4;
  endfunction

  function automatic logic [31:0] e_seed(input int k);
    return j_inc ? j_pat + 32'(k * j_len) : j_pat;
  endfunction

  task automatic start_job(input logic [31:0] bw, input int len, input bit wr, input bit inc,
                           input bit fix, input logic [63:0] base, input logic [31:0] pat);
    logic [31:0] r;
    j_base = base; j_pat = pat; j_len = len; j_wr = wr; j_inc = inc; j_fix = fix; j_k = 0;
    reg_wr(9'h000, base[31:0]);
    reg_wr(9'h004, base[63:32]);
    reg_wr(9'h010, pat);
    reg_wr(9'h008, bw);
    reg_wr(9'h014, 32'h0);
    reg_rd(9'h014, r);
    chk("R9 done cleared by zero write", 64'(r[0]), 64'd0);
    reg_wr(9'h00C, ctrl_word(1'b1, wr, len, inc, fix));
  endtask

  task automatic drain_n(input int n, input int pct);
    int got = 0;
    int guard = 0;
    bit stalled = 0;
    logic [63:0] sa = '0;
    logic [31:0] ss = '0;
    while (got < n) begin
      @(negedge clk); #1;
      if (stalled) begin
        chk("R8 valid held while stalled", 64'(dsc_valid), 64'd1);
        chk("R8 addr held while stalled", dsc_addr, sa);
        chk("R8 seed held while stalled", 64'(dsc_seed), 64'(ss));
      end
      guard++;
      if (guard > 4000) begin
        chk("R3 descriptor count (timeout)", 64'(got), 64'(n));
        break;
      end
      dsc_ready = (($urandom % 100) < 32'(pct));
      stalled = dsc_valid && !dsc_ready;
      sa = dsc_addr; ss = dsc_seed;
      if (dsc_valid && dsc_ready) begin
        chk("R5 descriptor address", dsc_addr, e_addr(j_k));
        chk("R6 descriptor seed", 64'(dsc_seed), 64'(e_seed(j_k)));
        chk("R6 increment flag", 64'(dsc_incr), 64'(j_inc));
        chk("R7 descriptor length", 64'(dsc_words), 64'(j_len));
        chk("R7 descriptor direction", 64'(dsc_write), 64'(j_wr));
        if (ctr_on) begin
          if (j_wr) exp_wr += 64'(j_len * 4);
          else      exp_rd += 64'(j_len * 4);
        end
        j_k++;
        got++;
      end
    end
  endtask

  task automatic finish_job();
    logic [31:0] r;
    @(negedge clk);
    dsc_ready = 1'b0;
    #1;
    chk("R3 no descriptor after run end", 64'(dsc_valid), 64'd0);
    reg_rd(9'h014, r);
    chk("R3 status done set, busy clear", 64'(r[1:0]), 64'd1);
  endtask

  task automatic run_job(input int cnt, input int len, input bit wr, input bit inc,
                         input bit fix, input logic [63:0] base, input logic [31:0] pat,
                         input int pct);
    start_job(32'(cnt), len, wr, inc, fix, base, pat);
    drain_n(cnt, pct);
    finish_job();
  endtask

  task automatic check_tallies(input string tag);
    logic [31:0] hi, lo;
    reg_rd(9'h104, hi); reg_rd(9'h100, lo);
    chk({tag, " write tally"}, {hi, lo}, exp_wr);
    reg_rd(9'h10C, hi); reg_rd(9'h108, lo);
    chk({tag, " read tally"}, {hi, lo}, exp_rd);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    summary();
  end

  initial begin
    logic [31:0] r, v;
    int unsigned seed_init;
    seed_init = $urandom(32'd5150);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;

    // R11: reset state
    chk("R11 valid low after reset", 64'(dsc_valid), 64'd0);
    for (int i = 0; i < 22; i++) begin
      reg_rd(9'(i * 4), r);
      chk("R11 register zero after reset", 64'(r), 64'd0);
    end
    for (int i = 0; i < 4; i++) begin
      reg_rd(9'(9'h100 + i * 4), r);
      chk("R11 tally zero after reset", 64'(r), 64'd0);
    end

    // R1: readback and reserved offsets
    v = $urandom; reg_wr(9'h018, v); reg_rd(9'h018, r); chk("R1 storage word 0", 64'(r), 64'(v));
    v = $urandom; reg_wr(9'h01C, v); reg_rd(9'h01C, r); chk("R1 storage word 1", 64'(r), 64'(v));
    v = $urandom; reg_wr(9'h010, v); reg_rd(9'h010, r); chk("R1 pattern word", 64'(r), 64'(v));
    v = $urandom; reg_wr(9'h004, v); reg_rd(9'h006, r); chk("R1 base high, low bits ignored", 64'(r), 64'(v));
    reg_wr(9'h020, 32'hFFFF_FFFF); reg_rd(9'h020, r); chk("R1 reserved offset reads zero", 64'(r), 64'd0);
    reg_rd(9'h05C, r); chk("R1 reserved offset 0x05C zero", 64'(r), 64'd0);
    reg_wr(9'h058, 32'hFFFF_FFFF); reg_rd(9'h058, r); chk("R1 counter enable reads bit 5 only", 64'(r), 64'h20);
    reg_wr(9'h100, 32'hFFFF_FFFF); reg_rd(9'h100, r); chk("R1 tally not writable", 64'(r), 64'd0);
    ctr_on = 1;

    // R2: doorbell bit pulses for one cycle
    reg_wr(9'h008, 32'h0);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 9'h00C; cfg_wdata = ctrl_word(1'b1, 1'b0, 5, 1'b0, 1'b1);
    @(negedge clk);
    cfg_we = 1'b0;
    reg_rd(9'h00C, r); chk("R2 doorbell reads 1 right after write", 64'(r[0]), 64'd1);
    @(negedge clk); #1;
    reg_rd(9'h00C, r); chk("R2 doorbell self-clears", 64'(r), 64'(ctrl_word(1'b0, 1'b0, 5, 1'b0, 1'b1)));
    reg_rd(9'h014, r); chk("R3 zero count sets done with no traffic", 64'(r[1:0]), 64'd1);
    chk("R3 zero count issues nothing", 64'(dsc_valid), 64'd0);

    // R9: done only cleared by a zero in bit 0
    reg_wr(9'h014, 32'h1); reg_rd(9'h014, r); chk("R9 write of 1 keeps done", 64'(r[0]), 64'd1);
    reg_wr(9'h014, 32'h0); reg_rd(9'h014, r); chk("R9 write of 0 clears done", 64'(r[0]), 64'd0);

    // directed corners
    run_job(1, 1, 1'b1, 1'b0, 1'b0, 64'h0000_0000_1000_0000, 32'h0, 100);
    run_job(0, 4, 1'b0, 1'b1, 1'b0, 64'h10, 32'h5, 100);
    run_job(4, 8, 1'b0, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFF0, 32'hFFFF_FFFE, 100);
    run_job(3, 4095, 1'b1, 1'b1, 1'b1, 64'h8000_0000, 32'h1234_5678, 60);
    check_tallies("R10 directed");

    // constrained random runs
    for (int t = 0; t < 14; t++) begin
      int unsigned c, l;
      logic [63:0] b;
      c = 1 + ($urandom % 6);
      l = 1 + ($urandom % 64);
      b = {$urandom, $urandom & 32'hFFFF_FFFC};
      run_job(int'(c), int'(l), 1'(($urandom >> 3) & 1), 1'(($urandom >> 5) & 1),
              1'(($urandom >> 7) & 1), b, $urandom, 30 + int'($urandom % 70));
    end
    check_tallies("R10 random");

    // R2: doorbell during a run is dropped
    start_job(32'd3, 6, 1'b1, 1'b0, 1'b0, 64'h4000, 32'hA5A5_0000);
    repeat (3) @(negedge clk);
    reg_wr(9'h00C, ctrl_word(1'b1, 1'b0, 9, 1'b1, 1'b1));
    drain_n(3, 100);
    finish_job();
    repeat (3) @(negedge clk);
    #1;
    chk("R2 busy doorbell not queued", 64'(dsc_valid), 64'd0);

    // R4: continuous mode stopped by read-modify-write
    start_job(32'h8000_0002, 16, 1'b0, 1'b1, 1'b0, 64'h2_0000_0000, 32'h100);
    drain_n(5, 100);
    @(negedge clk);
    dsc_ready = 1'b0;
    reg_rd(9'h008, r);
    chk("R4 repeat flag still set mid-run", 64'(r), 64'h8000_0002);
    reg_wr(9'h008, r & 32'h7FFF_FFFF);
    #1;
    chk("R4 traffic continues until the next acceptance", 64'(dsc_valid), 64'd1);
    drain_n(1, 100);
    finish_job();
    chk("R4 descriptors accepted in continuous run", 64'(j_k), 64'd6);
    reg_rd(9'h008, r);
    chk("R4 count bits preserved by repeat clear", 64'(r), 64'd2);
    check_tallies("R10 after repeat");

    // R10: disabled tallies hold
    reg_wr(9'h058, 32'h0);
    ctr_on = 0;
    run_job(5, 32, 1'b1, 1'b0, 1'b0, 64'h9000, 32'h0, 100);
    run_job(2, 32, 1'b0, 1'b0, 1'b1, 64'h9000, 32'h0, 100);
    check_tallies("R10 gated");

    summary();
  end
endmodule